// File: doc/BRIEF.md
# Physical Page List Walker

The walker converts one transfer descriptor into an ordered stream of address and length segments. A descriptor has a first pointer, a second pointer, a byte count and a page-size exponent. The first segment starts at the first pointer and runs no further than the end of that page. The rest of the transfer is covered either by the second pointer itself, when the remainder fits in one page, or by a list of page addresses held in memory that the second pointer locates. A full list can end in a link to a further list.

A data mover sits downstream. It consumes the segment stream through a valid/ready handshake and moves the data itself. The walker fetches list entries through a simple read port, one 64-bit word at a time. When the descriptor has been walked, or when a bad entry is found, it raises a one-cycle completion pulse. An error flag accompanies the pulse when the walk was aborted.

Top module: `page_walker`

## Requirements
- R1: During and after a synchronous active-high reset, `start_ready` is 1 and `seg_valid`, `done`, `err` and `mem_rd_valid` are 0.
- R2: The page size is P = 2^(12 + `desc_page_exp`). The first segment has address `desc_first_ptr` and length min(L, P - (`desc_first_ptr` mod P)), where L is `desc_len`.
- R3: If the remainder R left after the first segment satisfies 0 < R <= P, the only further segment is (`desc_second_ptr`, R), and no memory reads are issued.
- R4: In the case of R3, a `desc_second_ptr` that is not a multiple of P ends the walk with `done` and `err` high, and no second segment is produced.
- R5: If R > P, list slot i is read at address base + 8*i, starting from base = `desc_second_ptr`. The returned 64-bit word is a page address, and it yields a segment of length min(remaining, P). Slots are used in ascending order until the remainder is 0.
- R6: A list holds P/8 slots. When slot P/8-1 is reached while more than P bytes remain, its word becomes the new base and reading resumes at slot 0 of that list. Otherwise that slot is an ordinary data page.
- R7: A list word that is zero, or not a multiple of P, ends the walk with `done` and `err` high, and no segment is produced from it. This holds for link words as well as data words.
- R8: A zero `desc_len` produces no segment and no memory read, and ends with `done` high and `err` low.
- R9: `mem_rd_valid` is a one-cycle request. No new request is issued until `mem_rsp_valid` has returned the previous word.
- R10: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` hold. `done` pulses for one cycle after the last accepted segment, it is never high together with `seg_valid`, and `err` is only high with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Descriptor offered |
| start_ready | output | 1 | Walker idle, descriptor accepted on this cycle if offered |
| desc_first_ptr | input | 64 | Address of the first byte of the transfer |
| desc_second_ptr | input | 64 | Direct page address or list base |
| desc_len | input | 32 | Transfer length in bytes |
| desc_page_exp | input | MPS_W | Page size exponent above 4 KiB |
| mem_rd_valid | output | 1 | One-cycle read request for a list word |
| mem_rd_addr | output | 64 | Byte address of the requested list word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | List word, byte 0 in bits 7:0 |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment accepted when high with `seg_valid` |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment length in bytes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Walk aborted on an invalid pointer, valid with `done` |

## Verification
The hardest point to reach is the link slot. At the smallest page size it only appears after 511 data slots have been consumed, and it must be tested in two forms: with more than one page left, so the slot is followed as a link, and with exactly one page left, so it is used as data. The stimulus table uses transfer lengths of 514 and 513 pages, and the bench memory returns a word derived from each address. A further vector corrupts the link word itself. Bad entries are injected by overriding the memory word at one chosen address, which places the abort at a precise point in the walk.

// File: rtl/plw_pkg.sv
package plw_pkg;

    localparam int ADDR_W      = 64;
    localparam int LEN_W       = 32;
    localparam int BASE_SHIFT  = 12;
    localparam int ENTRY_SHIFT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DIRECT,
        ST_FETCH,
        ST_WAIT,
        ST_EMIT,
        ST_FINISH
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } seg_t;

    function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/plw_pgcalc.sv
module plw_pgcalc
    import plw_pkg::*;
#(
    parameter int MPS_W = 3
) (
    input  logic [MPS_W-1:0]  page_exp,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  pg_size,
    output logic [ADDR_W-1:0] pg_mask,
    output logic [LEN_W-1:0]  head_len
);

    logic [LEN_W-1:0] offs;
    logic [LEN_W-1:0] room;

    always_comb begin
        pg_size  = LEN_W'(1) << (BASE_SHIFT + int'(page_exp));
        pg_mask  = ADDR_W'(pg_size) - ADDR_W'(1);
        offs     = LEN_W'(ptr & pg_mask);
        room     = pg_size - offs;
        head_len = len_min(len, room);
    end

endmodule

// File: rtl/plw_entry_chk.sv
module plw_entry_chk
    import plw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] pg_mask,
    output logic              bad
);

    always_comb begin
        bad = (entry == '0) || ((entry & pg_mask) != '0);
    end

endmodule

// File: rtl/page_walker.sv
module page_walker
    import plw_pkg::*;
#(
    parameter int MPS_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_valid,
    output logic                 start_ready,
    input  logic [ADDR_W-1:0]    desc_first_ptr,
    input  logic [ADDR_W-1:0]    desc_second_ptr,
    input  logic [LEN_W-1:0]     desc_len,
    input  logic [MPS_W-1:0]     desc_page_exp,
    output logic                 mem_rd_valid,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ADDR_W-1:0]    mem_rsp_data,
    output logic                 seg_valid,
    input  logic                 seg_ready,
    output logic [ADDR_W-1:0]    seg_addr,
    output logic [LEN_W-1:0]     seg_len,
    output logic                 done,
    output logic                 err
);

    localparam int IDX_W = 9 + (2 ** MPS_W) - 1;

    walk_state_e       state_q;
    seg_t              seg_q;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] p2_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic [LEN_W-1:0]  pg_size_q;
    logic [ADDR_W-1:0] pg_mask_q;
    logic              err_q;

    logic [LEN_W-1:0]  calc_size;
    logic [ADDR_W-1:0] calc_mask;
    logic [LEN_W-1:0]  calc_head;
    logic              word_bad;
    logic [LEN_W-1:0]  rem_next;
    logic              p2_misaligned;

    plw_pgcalc #(.MPS_W(MPS_W)) pgcalc_i (
        .page_exp (desc_page_exp),
        .ptr      (desc_first_ptr),
        .len      (desc_len),
        .pg_size  (calc_size),
        .pg_mask  (calc_mask),
        .head_len (calc_head)
    );

    plw_entry_chk entry_chk_i (
        .entry   (mem_rsp_data),
        .pg_mask (pg_mask_q),
        .bad     (word_bad)
    );

    always_comb begin
        rem_next      = rem_q - seg_q.len;
        p2_misaligned = (p2_q & pg_mask_q) != '0;
        start_ready   = (state_q == ST_IDLE);
        seg_valid     = (state_q == ST_FIRST) || (state_q == ST_DIRECT) || (state_q == ST_EMIT);
        seg_addr      = seg_q.addr;
        seg_len       = seg_q.len;
        mem_rd_valid  = (state_q == ST_FETCH);
        mem_rd_addr   = base_q + {{(ADDR_W-IDX_W-ENTRY_SHIFT){1'b0}}, idx_q, {ENTRY_SHIFT{1'b0}}};
        done          = (state_q == ST_FINISH);
        err           = done && err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            seg_q      <= '0;
            rem_q      <= '0;
            p2_q       <= '0;
            base_q     <= '0;
            idx_q      <= '0;
            last_idx_q <= '0;
            pg_size_q  <= '0;
            pg_mask_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    err_q <= 1'b0;
                    if (start_valid) begin
                        pg_size_q  <= calc_size;
                        pg_mask_q  <= calc_mask;
                        last_idx_q <= IDX_W'((calc_size >> ENTRY_SHIFT) - LEN_W'(1));
                        p2_q       <= desc_second_ptr;
                        rem_q      <= desc_len;
                        seg_q      <= '{addr: desc_first_ptr, len: calc_head};
                        state_q    <= (desc_len == '0) ? ST_FINISH : ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (seg_ready) begin
                        rem_q <= rem_next;
                        if (rem_next == '0) begin
                            state_q <= ST_FINISH;
                        end else if (rem_next <= pg_size_q) begin
                            if (p2_misaligned) begin
                                err_q   <= 1'b1;
                                state_q <= ST_FINISH;
                            end else begin
                                seg_q   <= '{addr: p2_q, len: rem_next};
                                state_q <= ST_DIRECT;
                            end
                        end else begin
                            base_q  <= p2_q;
                            idx_q   <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_DIRECT: begin
                    if (seg_ready) begin
                        rem_q   <= '0;
                        state_q <= ST_FINISH;
                    end
                end
                ST_FETCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (word_bad) begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end else if ((idx_q == last_idx_q) && (rem_q > pg_size_q)) begin
                            base_q  <= mem_rsp_data;
                            idx_q   <= '0;
                            state_q <= ST_FETCH;
                        end else begin
                            seg_q   <= '{addr: mem_rsp_data, len: len_min(rem_q, pg_size_q)};
                            state_q <= ST_EMIT;
                        end
                    end
                end
                ST_EMIT: begin
                    if (seg_ready) begin
                        rem_q   <= rem_next;
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= (rem_next == '0) ? ST_FINISH : ST_FETCH;
                    end
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R1: an idle walker offers nothing downstream
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        start_ready |-> (!seg_valid && !done && !mem_rd_valid));

    // R9: a read request lasts one cycle and is never back to back
    assert_single_read_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    // R10: segment held under backpressure
    assert_seg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

    // R10: completion is exclusive with segments, error only with completion
    assert_done_alone_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !seg_valid);
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R5: every emitted segment is non-empty and no longer than a page
    assert_seg_len_R5: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> ((seg_len != '0) && (seg_len <= pg_size_q)));

    // R7: segments taken from list words are page aligned and non-zero
    assert_list_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMIT) |-> ((seg_addr != '0) && ((seg_addr & pg_mask_q) == '0)));

endmodule

// File: tb/page_walker_tb_top.sv
`timescale 1ns/1ps
module page_walker_tb_top;

    localparam int NV   = 12;
    localparam int MAXS = 1024;

    typedef struct packed {
        logic [63:0] p1;
        logic [63:0] p2;
        logic [31:0] len;
        logic [2:0]  mps;
        logic [63:0] bad_a;
        logic [63:0] bad_v;
        logic [15:0] exp_n;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    // R2 first only, R3 direct, R4 misaligned direct, R5 lists,
    // R6 link followed / last slot as data, R7 bad words, R8 zero length
    localparam vec_t TABLE [NV] = '{
        '{64'h1000_0100,   64'h2000, 32'h200,    3'd0, 64'h0,    64'h0,         16'd1,   1'b0, 8'd2},
        '{64'h1000_0800,   64'h5000, 32'h1000,   3'd0, 64'h0,    64'h0,         16'd2,   1'b0, 8'd3},
        '{64'h1000_0800,   64'h5004, 32'h1000,   3'd0, 64'h0,    64'h0,         16'd1,   1'b1, 8'd4},
        '{64'h1000_0000,   64'h8000, 32'h3800,   3'd0, 64'h0,    64'h0,         16'd4,   1'b0, 8'd5},
        '{64'h1_0000_1000, 64'h9000, 32'h5000,   3'd1, 64'h0,    64'h0,         16'd3,   1'b0, 8'd5},
        '{64'h1000_0000,   64'h2000, 32'h202000, 3'd0, 64'h0,    64'h0,         16'd514, 1'b0, 8'd6},
        '{64'h1000_0000,   64'h2000, 32'h201000, 3'd0, 64'h0,    64'h0,         16'd513, 1'b0, 8'd6},
        '{64'h1000_0000,   64'h8000, 32'h3800,   3'd0, 64'h8008, 64'h0,         16'd2,   1'b1, 8'd7},
        '{64'h1000_0000,   64'h8000, 32'h3800,   3'd0, 64'h8000, 64'h1234_5010, 16'd1,   1'b1, 8'd7},
        '{64'h1000_0000,   64'h2000, 32'h202000, 3'd0, 64'h2FF8, 64'h40,        16'd512, 1'b1, 8'd7},
        '{64'h3000,        64'h4000, 32'h0,      3'd0, 64'h0,    64'h0,         16'd0,   1'b0, 8'd8},
        '{64'h3FFC,        64'hC000, 32'h4004,   3'd2, 64'h0,    64'h0,         16'd2,   1'b0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [63:0] desc_first_ptr = '0;
    logic [63:0] desc_second_ptr = '0;
    logic [31:0] desc_len = '0;
    logic [2:0]  desc_page_exp = '0;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b1;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    int read_cnt = 0;
    logic [63:0] cur_bad_a = '0;
    logic [63:0] cur_bad_v = '0;

    logic [63:0] exp_addr [MAXS];
    logic [31:0] exp_len  [MAXS];
    int          exp_n;
    logic        exp_err;

    page_walker #(.MPS_W(3)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .start_valid     (start_valid),
        .start_ready     (start_ready),
        .desc_first_ptr  (desc_first_ptr),
        .desc_second_ptr (desc_second_ptr),
        .desc_len        (desc_len),
        .desc_page_exp   (desc_page_exp),
        .mem_rd_valid    (mem_rd_valid),
        .mem_rd_addr     (mem_rd_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .seg_valid       (seg_valid),
        .seg_ready       (seg_ready),
        .seg_addr        (seg_addr),
        .seg_len         (seg_len),
        .done            (done),
        .err             (err)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        if (cur_bad_a != 64'h0 && a == cur_bad_a) return cur_bad_v;
        return a << 16;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // memory responder, latency two cycles; R9 single outstanding read
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        logic [63:0] addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(addr);
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            if (mem_rd_valid) begin
                read_cnt++;
                check(!pend, "R9", "read issued while one outstanding", 64'd1, 64'd0);
                pend = 1;
                cnt  = 1;
                addr = mem_rd_addr;
            end
        end
    end

    task automatic push_exp(input logic [63:0] a, input logic [31:0] l);
        exp_addr[exp_n] = a;
        exp_len[exp_n]  = l;
        exp_n++;
    endtask

    task automatic build_expect(input vec_t v);
        logic [63:0] psz, base, w;
        logic [31:0] rem, first, l;
        int          i, ents;
        bit          fin;
        exp_n   = 0;
        exp_err = 1'b0;
        psz  = 64'd1 << (12 + int'(v.mps));
        ents = int'(psz >> 3);
        if (v.len == 0) return;
        first = ((64'(v.len)) < (psz - (v.p1 % psz))) ? v.len : 32'(psz - (v.p1 % psz));
        push_exp(v.p1, first);
        rem = v.len - first;
        if (rem == 0) return;
        if (64'(rem) <= psz) begin
            if ((v.p2 % psz) != 0) exp_err = 1'b1;
            else push_exp(v.p2, rem);
            return;
        end
        base = v.p2;
        i    = 0;
        fin  = 0;
        while (!fin) begin
            w = mem_word(base + 64'(8 * i));
            if (w == 0 || (w % psz) != 0) begin
                exp_err = 1'b1;
                fin = 1;
            end else if (i == ents - 1 && 64'(rem) > psz) begin
                base = w;
                i    = 0;
            end else begin
                l = (64'(rem) < psz) ? rem : 32'(psz);
                push_exp(w, l);
                rem = rem - l;
                i++;
                if (rem == 0) fin = 1;
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        string       rq;
        int          got_n = 0;
        logic        got_err = 1'b0;
        bit          finished = 0;
        bit          prev_stall = 0;
        logic [63:0] prev_addr = '0;
        logic [31:0] prev_len = '0;
        int          reads0;
        rq = $sformatf("R%0d", v.req);
        cur_bad_a = v.bad_a;
        cur_bad_v = v.bad_v;
        build_expect(v);
        @(negedge clk);
        start_valid     = 1'b1;
        desc_first_ptr  = v.p1;
        desc_second_ptr = v.p2;
        desc_len        = v.len;
        desc_page_exp   = v.mps;
        reads0          = read_cnt;
        @(negedge clk);
        start_valid = 1'b0;
        for (int c = 0; c < 20000 && !finished; c++) begin
            seg_ready = (vi % 2 == 0) ? 1'b1 : ((c % 3) != 1);
            if (prev_stall) begin
                check(seg_valid && seg_addr == prev_addr && seg_len == prev_len, "R10",
                      "segment changed under backpressure", seg_addr, prev_addr);
            end
            if (seg_valid && seg_ready) begin
                if (got_n < exp_n) begin
                    check(seg_addr == exp_addr[got_n], rq, $sformatf("vec %0d seg %0d addr", vi, got_n),
                          seg_addr, exp_addr[got_n]);
                    check(seg_len == exp_len[got_n], rq, $sformatf("vec %0d seg %0d len", vi, got_n),
                          64'(seg_len), 64'(exp_len[got_n]));
                end
                got_n++;
            end
            prev_stall = seg_valid && !seg_ready;
            prev_addr  = seg_addr;
            prev_len   = seg_len;
            if (done) begin
                finished = 1;
                got_err  = err;
            end else begin
                @(negedge clk);
            end
        end
        seg_ready = 1'b1;
        check(finished == 1, "R10", $sformatf("vec %0d completion seen", vi), 64'(finished), 64'd1);
        check(got_n == int'(v.exp_n), rq, $sformatf("vec %0d segment count", vi), 64'(got_n), 64'(v.exp_n));
        check(got_n == exp_n, rq, $sformatf("vec %0d model segment count", vi), 64'(got_n), 64'(exp_n));
        check(got_err == v.exp_err && got_err == exp_err, rq, $sformatf("vec %0d error flag", vi),
              64'(got_err), 64'(v.exp_err));
        if (v.len == 0) begin
            // R8: zero length issues no read
            check(read_cnt == reads0, "R8", "reads on zero length", 64'(read_cnt - reads0), 64'd0);
        end
        if (v.req == 3) begin
            // R3: direct second pointer needs no reads
            check(read_cnt == reads0, "R3", "reads on direct pointer", 64'(read_cnt - reads0), 64'd0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: outputs during reset
        check(start_ready && !seg_valid && !done && !err && !mem_rd_valid, "R1", "state in reset",
              {59'd0, start_ready, seg_valid, done, err, mem_rd_valid}, 64'h10);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(start_ready && !seg_valid && !done && !err && !mem_rd_valid, "R1", "state after reset",
              {59'd0, start_ready, seg_valid, done, err, mem_rd_valid}, 64'h10);
        for (int v = 0; v < NV; v++) begin
            run_vec(TABLE[v], v);
        end
        // R10: done lasts a single cycle, then the walker is idle again
        @(negedge clk);
        check(!done && start_ready, "R10", "done is one cycle", 64'(done), 64'd0);
        // R1: a mid-walk reset returns the walker to idle
        @(negedge clk);
        cur_bad_a       = 64'h0;
        start_valid     = 1'b1;
        desc_first_ptr  = 64'h1000_0000;
        desc_second_ptr = 64'h8000;
        desc_len        = 32'h3800;
        desc_page_exp   = 3'd0;
        seg_ready       = 1'b0;
        @(negedge clk);
        start_valid = 1'b0;
        check(seg_valid, "R2", "segment pending before reset", 64'(seg_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seg_ready = 1'b1;
        @(negedge clk);
        check(start_ready && !seg_valid && !done, "R1", "idle after mid-walk reset",
              64'(start_ready), 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule